// File: doc/BRIEF.md
# Floating-Point Multiply Exception Detector

This block sits beside a floating-point multiplier for a sign-magnitude format. The mantissa is an unsigned fraction with an implied leading zero. The exponent is an unsigned code that carries an offset of 2^(EXP_W-1). The sign convention is 1 for positive and 0 for negative.

The block sees the two input operands, the post-normalization left-shift count, and the product exponent twice. Both copies of the exponent are computed one bit wider than the exponent field. The first copy is taken after the operand exponents are added and the offset is removed. The second copy is taken after the normalization correction.

From these inputs the block reports one of five conditions:
- not-a-number
- infinity
- zero
- overflow
- underflow

It also reports the result sign. The flags are decided combinationally and are registered once, so they line up with a registered datapath result. The block only reports. It never alters the product.

Top module: `fpm_exc_detect`

## Requirements
- R1: An operand is zero when its mantissa and exponent are both 0. It is infinite when its mantissa is 0 and its exponent is the all-ones code. It is not-a-number when its exponent is the all-ones code and its mantissa is nonzero. Any other pattern, including mantissa 0 with any other exponent, is finite and nonzero.
- R2: `o_nan` is raised when either operand is not-a-number, or when one operand is zero and the other is infinite.
- R3: `o_inf` is raised when at least one operand is infinite and R2 does not apply.
- R4: `o_zero` is raised when at least one operand is zero and neither R2 nor R3 applies.
- R5: `o_ovf` is raised when bit EXP_W of both `exp_pre` and `exp_post` is 1, and none of R2 to R4 applies.
- R6: `o_unf` is raised when bit EXP_W is 0 in `exp_pre`, bit EXP_W is 1 in `exp_post`, `norm_shift` is nonzero, and none of R2 to R4 applies.
- R7: When bit EXP_W is 1 in `exp_pre` but 0 in `exp_post`, no range flag is raised. The normalization has brought the exponent back into range.
- R8: At most one of the five flags is high in any cycle. The priority order is not-a-number, then infinity, then zero, then overflow or underflow.
- R9: `o_sign` is the XNOR of the two operand signs.
- R10: All outputs change exactly one clock edge after their inputs. An asynchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sign | input | 1 | Sign of operand A (1 = positive) |
| a_mant | input | MANT_W | Fractional mantissa of operand A |
| a_exp | input | EXP_W | Offset exponent code of operand A |
| b_sign | input | 1 | Sign of operand B (1 = positive) |
| b_mant | input | MANT_W | Fractional mantissa of operand B |
| b_exp | input | EXP_W | Offset exponent code of operand B |
| exp_pre | input | EXP_W+1 | Extended exponent after the add and the offset removal |
| exp_post | input | EXP_W+1 | Extended exponent after the normalization correction |
| norm_shift | input | SHIFT_W | Left-shift count applied by normalization |
| o_sign | output | 1 | Result sign, registered |
| o_nan | output | 1 | Not-a-number or invalid operation, registered |
| o_inf | output | 1 | Infinite result, registered |
| o_zero | output | 1 | Zero result, registered |
| o_ovf | output | 1 | Exponent overflow, registered |
| o_unf | output | 1 | Exponent underflow, registered |

## Verification
The block keeps only one register of state, the flag and sign stage. Any fault in that stage therefore shows on the ports one edge after the bad inputs arrive, and clears one edge later.

The classification logic can go wrong in a few visible ways:
- A wrong priority shows up as two flags high at once.
- A wrong priority can also show up as a special operand that is masked by a range flag.
- An operand decoder that misreads the exponent or mantissa boundary flips the flag for the near-miss patterns: mantissa 0 with exponent code one below all-ones, and mantissa 0 with exponent code 1.

The stimulus therefore pairs every special operand with range inputs that would otherwise raise a flag.

// File: rtl/fpm_exc_detect.sv
module fpm_exc_detect #(
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 7,
  parameter int SHIFT_W = $clog2(2*MANT_W+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_sign,
  input  logic [MANT_W-1:0]  a_mant,
  input  logic [EXP_W-1:0]   a_exp,
  input  logic               b_sign,
  input  logic [MANT_W-1:0]  b_mant,
  input  logic [EXP_W-1:0]   b_exp,
  input  logic [EXP_W:0]     exp_pre,
  input  logic [EXP_W:0]     exp_post,
  input  logic [SHIFT_W-1:0] norm_shift,
  output logic               o_sign,
  output logic               o_nan,
  output logic               o_inf,
  output logic               o_zero,
  output logic               o_ovf,
  output logic               o_unf
);

  localparam logic [EXP_W-1:0] EXP_RSVD = '1;

  // R1: operand classes
  logic a_mz, b_mz, a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_mz   = (a_mant == '0);
  assign b_mz   = (b_mant == '0);
  assign a_zero = a_mz && (a_exp == '0);
  assign b_zero = b_mz && (b_exp == '0);
  assign a_inf  = a_mz && (a_exp == EXP_RSVD);
  assign b_inf  = b_mz && (b_exp == EXP_RSVD);
  assign a_nan  = !a_mz && (a_exp == EXP_RSVD);
  assign b_nan  = !b_mz && (b_exp == EXP_RSVD);

  logic n_nan, n_inf, n_zero, special, n_ovf, n_unf;
  assign n_nan   = a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero);
  assign n_inf   = !n_nan && (a_inf || b_inf);
  assign n_zero  = !n_nan && !n_inf && (a_zero || b_zero);
  assign special = a_nan || b_nan || a_inf || b_inf || a_zero || b_zero;
  assign n_ovf   = !special && exp_pre[EXP_W] && exp_post[EXP_W];
  assign n_unf   = !special && !exp_pre[EXP_W] && exp_post[EXP_W] && (norm_shift != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_sign <= 1'b0;
      o_nan  <= 1'b0;
      o_inf  <= 1'b0;
      o_zero <= 1'b0;
      o_ovf  <= 1'b0;
      o_unf  <= 1'b0;
    end else begin
      o_sign <= ~(a_sign ^ b_sign);
      o_nan  <= n_nan;
      o_inf  <= n_inf;
      o_zero <= n_zero;
      o_ovf  <= n_ovf;
      o_unf  <= n_unf;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_nan, o_inf, o_zero, o_ovf, o_unf})); // R8

  AST_ZERO_TIMES_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mant == '0 && a_exp == '0 && b_mant == '0 && b_exp == EXP_RSVD) |=> o_nan); // R2

  AST_OVF_NEEDS_MSBS: assert property (@(posedge clk) disable iff (!rst_n)
    o_ovf |-> ($past(exp_pre[EXP_W]) && $past(exp_post[EXP_W]))); // R5

  AST_UNF_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    o_unf |-> ($past(norm_shift) != '0 && !$past(exp_pre[EXP_W]))); // R6

  AST_SIGN_XNOR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (o_sign == $past(~(a_sign ^ b_sign)))); // R9

endmodule

// File: tb/test_fpm_exc_detect.sv
`timescale 1ns/1ps
module test_fpm_exc_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sign, b_sign;
  logic [7:0] a_mant, b_mant;
  logic [6:0] a_exp, b_exp;
  logic [7:0] exp_pre, exp_post;
  logic [4:0] norm_shift;
  logic o_sign, o_nan, o_inf, o_zero, o_ovf, o_unf;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpm_exc_detect i_fpm_exc_detect (
    .clk(clk), .rst_n(rst_n),
    .a_sign(a_sign), .a_mant(a_mant), .a_exp(a_exp),
    .b_sign(b_sign), .b_mant(b_mant), .b_exp(b_exp),
    .exp_pre(exp_pre), .exp_post(exp_post), .norm_shift(norm_shift),
    .o_sign(o_sign), .o_nan(o_nan), .o_inf(o_inf), .o_zero(o_zero),
    .o_ovf(o_ovf), .o_unf(o_unf));

  // {sa, ma, ea, sb, mb, eb, pre, post, shift, flags{nan,inf,zero,ovf,unf}, sign}
  localparam int NV = 16;
  localparam logic [58:0] VEC [NV] = '{
    {1'b1,8'h9C,7'd80, 1'b1,8'hCB,7'd78, 8'h5E,8'h5B,5'd3, 5'b00000,1'b1}, // R5 R6 in range
    {1'b1,8'h80,7'd120,1'b0,8'h80,7'd120,8'hB0,8'hAF,5'd1, 5'b00010,1'b0}, // R5 overflow
    {1'b0,8'h80,7'd100,1'b0,8'h80,7'd92, 8'h80,8'h7F,5'd1, 5'b00000,1'b1}, // R7 corrected
    {1'b0,8'h81,7'd30, 1'b0,8'h81,7'd36, 8'h02,8'hFD,5'd5, 5'b00001,1'b1}, // R6 underflow
    {1'b1,8'h00,7'd0,  1'b1,8'h90,7'd10, 8'hCA,8'hBA,5'd16,5'b00100,1'b1}, // R4 zero over ovf
    {1'b0,8'h90,7'd10, 1'b1,8'h00,7'd0,  8'h05,8'hFF,5'd6, 5'b00100,1'b0}, // R4 zero over unf
    {1'b0,8'h00,7'd127,1'b1,8'hC0,7'd70, 8'h85,8'h84,5'd1, 5'b01000,1'b0}, // R3 inf over ovf
    {1'b1,8'h00,7'd0,  1'b1,8'h00,7'd127,8'h3F,8'h3F,5'd0, 5'b10000,1'b1}, // R2 zero x inf
    {1'b0,8'h00,7'd127,1'b1,8'h00,7'd0,  8'h3F,8'h3F,5'd0, 5'b10000,1'b0}, // R2 inf x zero
    {1'b1,8'h40,7'd127,1'b1,8'h88,7'd64, 8'h7F,8'h7F,5'd0, 5'b10000,1'b1}, // R1 R2 nan operand
    {1'b0,8'h00,7'd127,1'b0,8'h00,7'd127,8'hBE,8'hBE,5'd0, 5'b01000,1'b1}, // R3 inf x inf
    {1'b1,8'h00,7'd0,  1'b0,8'h00,7'd0,  8'hC0,8'hC0,5'd0, 5'b00100,1'b0}, // R4 zero x zero
    {1'b1,8'h00,7'd126,1'b1,8'h80,7'd64, 8'h7E,8'h7E,5'd0, 5'b00000,1'b1}, // R1 near-miss inf
    {1'b0,8'h00,7'd1,  1'b1,8'h80,7'd64, 8'h01,8'h01,5'd0, 5'b00000,1'b0}, // R1 near-miss zero
    {1'b1,8'hFF,7'd126,1'b1,8'hFF,7'd126,8'hC0,8'hC0,5'd0, 5'b00010,1'b1}, // R5 R8 ovf no shift
    {1'b0,8'h80,7'd64, 1'b0,8'h80,7'd64, 8'h40,8'hC0,5'd0, 5'b00000,1'b1}  // R6 no shift, no unf
  };

  task automatic drive(input logic [58:0] v);
    {a_sign, a_mant, a_exp, b_sign, b_mant, b_exp, exp_pre, exp_post, norm_shift} = v[58:6];
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: flags/sign actual %b expected %b", req, act, exp_v);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      1: return "R5";  2: return "R7";  3: return "R6";  4, 5: return "R4";
      6: return "R3";  7, 8: return "R2"; 9: return "R1"; 10: return "R3";
      11: return "R4"; 12, 13: return "R1"; 14: return "R8"; 15: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(VEC[1]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, 6'b000000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check(tag_of(i), {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, VEC[i][5:0]);
    end
    // R10: one-edge latency, old value held until the edge
    @(negedge clk);
    drive(VEC[3]);
    @(negedge clk);
    drive(VEC[7]);
    #1;
    check("R10 hold", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, VEC[3][5:0]);
    @(negedge clk);
    check("R10 next", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, VEC[7][5:0]);
    // R9: sign only differs
    @(negedge clk);
    drive(VEC[0]);
    a_sign = 1'b0;
    b_sign = 1'b1;
    @(negedge clk);
    check("R9", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, 6'b000000);
    // R10: asynchronous reset clears outputs mid-run
    drive(VEC[1]);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R10 async", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, 6'b000000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 after reset", {o_nan,o_inf,o_zero,o_ovf,o_unf,o_sign}, VEC[1][5:0]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule